// File: doc/BRIEF.md
# History-Correlated Probabilistic Row Sampler

This block tracks row activations for one DRAM bank and decides which rows need a neighbour refresh to counter read-disturb (RowHammer) attacks. It splits the activation stream into fixed windows of `WIN` activations. At the first activation of each window it draws up to `SAMPLES` slot positions from a random input. The row activated in each drawn slot is captured. The first capture of a window is sent to the regular mitigation path, so the regular rate stays at one row per window.

Captures after the first are not mitigated straight away. Each one is compared, in the cycle it arrives, against a small history of earlier unmitigated captures. A capture with no match is added to the history, where it stays matchable for `LIFE` windows. A capture that matches is queued as an extra mitigation. The block holds a request line high until the memory controller acknowledges it, one queued row at a time. Extra work is therefore spent only on rows that keep being sampled. Refresh execution, the random source and the controller are outside the block.

Top module: `rhs_sampler`

## Requirements
- R1: After a synchronous reset, `mit_valid_o` and `alert_o` are low, the window position is zero, and no earlier capture can cause an alert.
- R2: Activations are counted from slot 0 within each window of `WIN` activations. At slot 0, draw k is `rnd_i[k*SLOT_W +: SLOT_W] % WIN`. A draw equal to an earlier draw of the same window is skipped. Only slots that were drawn are captured.
- R3: The first capture of a window produces a one-cycle `mit_valid_o` pulse, carrying that row on `mit_row_o`, in the cycle after the activation. There is at most one such pulse per window.
- R4: Every later capture in the window is compared against the live history entries. When there is no match, the row is recorded in the history.
- R5: A row recorded during window n can match during windows n to n+LIFE-1 and cannot match from window n+LIFE onward.
- R6: A later capture that matches the history, while the pending queue is not full, queues that row for an alert. The same activation removes every history entry holding that row.
- R7: While the pending queue is non-empty, `alert_o` is high and `alert_row_o` shows the oldest queued row, held stable until `alert_ack_i`. Each acknowledge removes one row, in arrival order. An acknowledge while `alert_o` is low has no effect.
- R8: A match while the pending queue holds `PEND` rows is dropped. The matching entry stays valid and nothing new is recorded.
- R9: An activation is accepted on every cycle that `act_i` is high, with no stall. Cycles with `act_i` low do not advance the window.
- R10: A capture other than the first in its window never produces `mit_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| act_i | input | 1 | One row activation this cycle |
| act_row_i | input | ROW_W | Row address of the activation |
| rnd_i | input | SAMPLES*SLOT_W | Random bits; used at slot 0 of each window |
| alert_ack_i | input | 1 | Controller acknowledges the current alert row |
| mit_valid_o | output | 1 | Regular mitigation request pulse |
| mit_row_o | output | ROW_W | Row for the regular mitigation |
| alert_o | output | 1 | Extra mitigation request |
| alert_row_o | output | ROW_W | Row for the extra mitigation |

## Verification
The assertions check on every cycle the following properties:
- at most one regular capture falls in each window;
- a mitigation pulse follows an activation;
- a later capture never raises the regular pulse;
- the alert row holds steady until it is acknowledged;
- a rising alert follows a history hit;
- outputs are quiet after reset.

The bench scenarios cover what only a sequence of windows can show:
- the slot draws, including duplicate and modulo-aliased draws;
- a row recorded during one window still matching LIFE-1 windows later, but not LIFE windows later;
- a matched entry that can match only after it is recorded again;
- drops when the pending queue is full, with the entry kept;
- idle gaps that do not move the window;
- history cleared by a reset in mid-stream.

// File: rtl/rhs_pkg.sv
package rhs_pkg;

  // Reduce a raw random draw to a slot position inside a window.
  function automatic int unsigned slot_wrap(input int unsigned raw, input int unsigned win);
    return raw % win;
  endfunction

  // Advance an index around a ring of the given length.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned len);
    return (idx + 1 == len) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/rhs_slot_picker.sv
module rhs_slot_picker #(
  parameter int WIN     = 72,
  parameter int SAMPLES = 3,
  parameter int SLOT_W  = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        act_i,
  input  logic [SAMPLES*SLOT_W-1:0]   rnd_i,
  output logic                        regular_o,
  output logic                        extra_o,
  output logic                        win_end_o
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [CW-1:0]      cnt_q;
  logic [CW-1:0]      slot_q [SAMPLES];
  logic [SAMPLES-1:0] en_q;
  logic               taken_q;

  logic [CW-1:0]      slot_c [SAMPLES];
  logic [SAMPLES-1:0] en_c;
  logic               start_c, hit_c, taken_c;

  always_comb begin
    start_c = (cnt_q == '0);
    for (int k = 0; k < SAMPLES; k++) begin
      slot_c[k] = start_c
        ? CW'(rhs_pkg::slot_wrap(32'(rnd_i[k*SLOT_W +: SLOT_W]), WIN))
        : slot_q[k];
    end
    for (int k = 0; k < SAMPLES; k++) begin
      en_c[k] = start_c ? 1'b1 : en_q[k];
      for (int j = 0; j < SAMPLES; j++) begin
        if (start_c && (j < k) && (slot_c[j] == slot_c[k])) en_c[k] = 1'b0;
      end
    end
    hit_c = 1'b0;
    for (int k = 0; k < SAMPLES; k++) begin
      if (en_c[k] && (slot_c[k] == cnt_q)) hit_c = 1'b1;
    end
    taken_c = start_c ? 1'b0 : taken_q;
  end

  assign regular_o = act_i && hit_c && !taken_c;
  assign extra_o   = act_i && hit_c && taken_c;
  assign win_end_o = act_i && (cnt_q == CW'(WIN - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      taken_q <= 1'b0;
      en_q    <= '0;
      for (int k = 0; k < SAMPLES; k++) slot_q[k] <= '0;
    end else if (act_i) begin
      cnt_q   <= win_end_o ? '0 : cnt_q + 1'b1;
      taken_q <= win_end_o ? 1'b0 : (taken_c | hit_c);
      if (start_c) begin
        en_q <= en_c;
        for (int k = 0; k < SAMPLES; k++) slot_q[k] <= slot_c[k];
      end
    end
  end
endmodule

// File: rtl/rhs_history.sv
module rhs_history #(
  parameter int ROW_W   = 16,
  parameter int GENS    = 4,
  parameter int PER_GEN = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             wr_i,
  input  logic             drop_hits_i,
  input  logic             win_end_i,
  output logic             hit_o
);
  localparam int GW = (GENS > 1) ? $clog2(GENS) : 1;
  localparam int PW = (PER_GEN > 1) ? $clog2(PER_GEN) : 1;

  logic             vld_q [GENS][PER_GEN];
  logic [ROW_W-1:0] row_q [GENS][PER_GEN];
  logic [GW-1:0]    gen_q;
  logic [PW-1:0]    wp_q;
  logic [GW-1:0]    gen_nx;

  assign gen_nx = GW'(rhs_pkg::ring_next(32'(gen_q), GENS));

  always_comb begin
    hit_o = 1'b0;
    for (int g = 0; g < GENS; g++)
      for (int e = 0; e < PER_GEN; e++)
        if (vld_q[g][e] && (row_q[g][e] == row_i)) hit_o = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gen_q <= '0;
      wp_q  <= '0;
      for (int g = 0; g < GENS; g++)
        for (int e = 0; e < PER_GEN; e++) vld_q[g][e] <= 1'b0;
    end else begin
      if (drop_hits_i) begin
        for (int g = 0; g < GENS; g++)
          for (int e = 0; e < PER_GEN; e++)
            if (vld_q[g][e] && (row_q[g][e] == row_i)) vld_q[g][e] <= 1'b0;
      end
      if (wr_i) begin
        vld_q[gen_q][wp_q] <= 1'b1;
        row_q[gen_q][wp_q] <= row_i;
        wp_q               <= wp_q + 1'b1;
      end
      if (win_end_i) begin
        gen_q <= gen_nx;
        wp_q  <= '0;
        for (int e = 0; e < PER_GEN; e++) vld_q[gen_nx][e] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rhs_alert_fifo.sv
module rhs_alert_fifo #(
  parameter int ROW_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             push_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             pop_i,
  output logic             vld_o,
  output logic [ROW_W-1:0] row_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [ROW_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [NW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign vld_o   = (cnt_q != '0);
  assign full_o  = (cnt_q == NW'(DEPTH));
  assign row_o   = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && vld_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= row_i;
        wr_q        <= AW'(rhs_pkg::ring_next(32'(wr_q), DEPTH));
      end
      if (do_pop) rd_q <= AW'(rhs_pkg::ring_next(32'(rd_q), DEPTH));
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rhs_sampler.sv
module rhs_sampler #(
  parameter int WIN     = 72,
  parameter int SAMPLES = 3,
  parameter int SLOT_W  = 7,
  parameter int ROW_W   = 16,
  parameter int LIFE    = 4,
  parameter int PEND    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      act_i,
  input  logic [ROW_W-1:0]          act_row_i,
  input  logic [SAMPLES*SLOT_W-1:0] rnd_i,
  input  logic                      alert_ack_i,
  output logic                      mit_valid_o,
  output logic [ROW_W-1:0]          mit_row_o,
  output logic                      alert_o,
  output logic [ROW_W-1:0]          alert_row_o
);
  localparam int PER_GEN = SAMPLES - 1;

  // Named internal events, observed by the bound checker.
  logic regular_w, extra_w, win_end_w;
  logic hit_w, push_w, hist_wr_w, full_w;

  rhs_slot_picker #(.WIN(WIN), .SAMPLES(SAMPLES), .SLOT_W(SLOT_W)) u_pick (
    .clk_i(clk_i), .rst_i(rst_i), .act_i(act_i), .rnd_i(rnd_i),
    .regular_o(regular_w), .extra_o(extra_w), .win_end_o(win_end_w)
  );

  assign push_w    = extra_w && hit_w && !full_w;
  assign hist_wr_w = extra_w && !hit_w;

  rhs_history #(.ROW_W(ROW_W), .GENS(LIFE), .PER_GEN(PER_GEN)) u_hist (
    .clk_i(clk_i), .rst_i(rst_i), .row_i(act_row_i),
    .wr_i(hist_wr_w), .drop_hits_i(push_w), .win_end_i(win_end_w),
    .hit_o(hit_w)
  );

  rhs_alert_fifo #(.ROW_W(ROW_W), .DEPTH(PEND)) u_pend (
    .clk_i(clk_i), .rst_i(rst_i), .push_i(push_w), .row_i(act_row_i),
    .pop_i(alert_ack_i), .vld_o(alert_o), .row_o(alert_row_o), .full_o(full_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mit_valid_o <= 1'b0;
      mit_row_o   <= '0;
    end else begin
      mit_valid_o <= regular_w;
      if (regular_w) mit_row_o <= act_row_i;
    end
  end
endmodule

// File: rtl/rhs_sampler_chk.sv
module rhs_sampler_chk #(
  parameter int ROW_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             act_i,
  input logic             alert_ack_i,
  input logic             mit_valid_o,
  input logic             alert_o,
  input logic [ROW_W-1:0] alert_row_o,
  input logic             regular_w,
  input logic             extra_w,
  input logic             win_end_w,
  input logic             hit_w
);
  logic mit_in_win_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)          mit_in_win_q <= 1'b0;
    else if (win_end_w) mit_in_win_q <= 1'b0;
    else if (regular_w) mit_in_win_q <= 1'b1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (!alert_o && !mit_valid_o));

  a_r3_one_regular_per_window: assert property (@(posedge clk_i) disable iff (rst_i)
    regular_w |-> !mit_in_win_q);

  a_r3_mit_follows_act: assert property (@(posedge clk_i) disable iff (rst_i)
    mit_valid_o |-> $past(act_i));

  a_r6_alert_rise_needs_hit: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(alert_o) |-> $past(hit_w));

  a_r7_alert_held: assert property (@(posedge clk_i) disable iff (rst_i)
    (alert_o && !alert_ack_i) |=> (alert_o && $stable(alert_row_o)));

  a_r10_extra_not_regular: assert property (@(posedge clk_i) disable iff (rst_i)
    extra_w |=> !mit_valid_o);

  a_r9_single_role: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({regular_w, extra_w}));
endmodule

bind rhs_sampler rhs_sampler_chk #(.ROW_W(ROW_W)) i_chk (
  .clk_i(clk_i), .rst_i(rst_i), .act_i(act_i), .alert_ack_i(alert_ack_i),
  .mit_valid_o(mit_valid_o), .alert_o(alert_o), .alert_row_o(alert_row_o),
  .regular_w(regular_w), .extra_w(extra_w), .win_end_w(win_end_w), .hit_w(hit_w)
);

// File: tb/test_rhs_sampler.sv
module test_rhs_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 72, NS = 3, SW = 7, RW = 16, LIFE = 4, PEND = 4;

  logic clk = 1'b0, rst_i = 1'b1, act_i = 1'b0, alert_ack_i = 1'b0;
  logic [RW-1:0] act_row_i = '0;
  logic [NS*SW-1:0] rnd_i = '0;
  logic mit_valid_o, alert_o;
  logic [RW-1:0] mit_row_o, alert_row_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rhs_sampler #(.WIN(WIN), .SAMPLES(NS), .SLOT_W(SW), .ROW_W(RW), .LIFE(LIFE), .PEND(PEND))
  i_rhs_sampler (
    .clk_i(clk), .rst_i(rst_i), .act_i(act_i), .act_row_i(act_row_i), .rnd_i(rnd_i),
    .alert_ack_i(alert_ack_i), .mit_valid_o(mit_valid_o), .mit_row_o(mit_row_o),
    .alert_o(alert_o), .alert_row_o(alert_row_o)
  );

  int n_chk = 0, n_fail = 0;
  int cnt_m = 0, win_m = 0;
  int slot_m [NS];
  bit en_m [NS];
  bit taken_m = 0;
  logic [RW-1:0] h_row [$];
  int            h_birth [$];
  logic [RW-1:0] pq [$];
  bit exp_mv;
  logic [RW-1:0] exp_mr;
  logic [RW-1:0] uniq = 16'h4000;
  string tag_m = "R3", tag_a = "R7";

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic void model_clear();
    cnt_m = 0; win_m = 0; taken_m = 0;
    h_row.delete(); h_birth.delete(); pq.delete();
  endfunction

  function automatic void model_step(input bit a, input logic [RW-1:0] row,
                                     input logic [NS*SW-1:0] rnd, input bit ack);
    int  pre = pq.size();
    bit  samp = 0, tk, hit = 0;
    exp_mv = 0;
    if (ack && pre > 0) void'(pq.pop_front());
    if (!a) return;
    if (cnt_m == 0) begin
      for (int k = 0; k < NS; k++) begin
        slot_m[k] = int'(rnd[k*SW +: SW]) % WIN;
        en_m[k] = 1;
        for (int j = 0; j < k; j++) if (slot_m[j] == slot_m[k]) en_m[k] = 0;
      end
    end
    for (int k = 0; k < NS; k++) if (en_m[k] && slot_m[k] == cnt_m) samp = 1;
    tk = (cnt_m == 0) ? 0 : taken_m;
    if (samp && !tk) begin exp_mv = 1; exp_mr = row; end
    if (samp && tk) begin
      for (int i = h_row.size() - 1; i >= 0; i--)
        if (win_m - h_birth[i] >= LIFE) begin h_row.delete(i); h_birth.delete(i); end
      foreach (h_row[i]) if (h_row[i] == row) hit = 1;
      if (hit && pre < PEND) begin
        pq.push_back(row);
        for (int i = h_row.size() - 1; i >= 0; i--)
          if (h_row[i] == row) begin h_row.delete(i); h_birth.delete(i); end
      end else if (!hit) begin
        h_row.push_back(row); h_birth.push_back(win_m);
      end
    end
    taken_m = tk | samp;
    cnt_m++;
    if (cnt_m == WIN) begin cnt_m = 0; win_m++; taken_m = 0; end
  endfunction

  task automatic cyc(input bit a, input logic [RW-1:0] row, input logic [NS*SW-1:0] rnd, input bit ack);
    act_i = a; act_row_i = row; rnd_i = rnd; alert_ack_i = ack;
    model_step(a, row, rnd, ack);
    @(posedge clk); @(negedge clk);
    check(tag_m, "mit_valid", 32'(mit_valid_o), 32'(exp_mv));
    if (exp_mv) check(tag_m, "mit_row", 32'(mit_row_o), 32'(exp_mr));
    check(tag_a, "alert", 32'(alert_o), 32'(pq.size() != 0));
    if (pq.size() != 0) check(tag_a, "alert_row", 32'(alert_row_o), 32'(pq[0]));
  endtask

  // One whole window; rows are unique except at up to two chosen slots.
  task automatic run_win(input logic [NS*SW-1:0] rnd, input int sa, input logic [RW-1:0] ra,
                         input int sb, input logic [RW-1:0] rb);
    for (int c = 0; c < WIN; c++) begin
      logic [RW-1:0] r;
      if (c == sa) r = ra;
      else if (c == sb) r = rb;
      else begin r = uniq; uniq++; end
      cyc(1'b1, r, rnd, 1'b0);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < PEND + 1; i++) cyc(1'b0, '0, '0, 1'b1);
  endtask

  task automatic do_reset();
    act_i = 0; alert_ack_i = 0; rst_i = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_i = 0;
    model_clear();
    check("R1", "mit_valid after reset", 32'(mit_valid_o), 0);
    check("R1", "alert after reset", 32'(alert_o), 0);
  endtask

  localparam logic [NS*SW-1:0] RND123 = {7'd3, 7'd2, 7'd1};

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: distinct draws and aliased draws
    tag_m = "R2"; tag_a = "R4";
    run_win({7'd20, 7'd10, 7'd5}, -1, '0, -1, '0);
    run_win({7'd81, 7'd9, 7'd9}, -1, '0, -1, '0);
    run_win({7'd127, 7'd0, 7'd71}, -1, '0, -1, '0);

    // R6: reappearance in the same window, then removal of the entry
    tag_m = "R3"; tag_a = "R6";
    run_win(RND123, 2, 16'h0AA0, 3, 16'h0AA0);
    run_win(RND123, 2, 16'h0AA0, -1, '0);
    run_win(RND123, 3, 16'h0AA0, -1, '0);
    tag_a = "R7"; drain();

    // R5: lifetime edge
    tag_a = "R5";
    run_win(RND123, 2, 16'h0BB0, -1, '0);
    for (int w = 0; w < LIFE - 2; w++) run_win(RND123, -1, '0, -1, '0);
    run_win(RND123, 2, 16'h0BB0, -1, '0);
    drain();
    run_win(RND123, 2, 16'h0CC0, -1, '0);
    for (int w = 0; w < LIFE - 1; w++) run_win(RND123, -1, '0, -1, '0);
    run_win(RND123, 2, 16'h0CC0, -1, '0);

    // R8: full pending queue drops matches but keeps entries
    tag_a = "R8";
    for (int w = 0; w < PEND + 2; w++) run_win(RND123, 2, 16'h0D00 + 16'(w), 3, 16'h0D00 + 16'(w));
    drain();
    run_win(RND123, 2, 16'h0D00 + 16'(PEND + 1), -1, '0);
    drain();

    // R9: idle gaps and stray acknowledges
    tag_m = "R9"; tag_a = "R9";
    for (int i = 0; i < 600; i++)
      cyc(1'($urandom_range(0, 1)), 16'($urandom_range(0, 3)), 21'($urandom), 1'($urandom_range(0, 1)));
    drain();

    // R1: reset clears history mid-stream
    tag_m = "R1"; tag_a = "R1";
    run_win(RND123, 2, 16'h0777, -1, '0);
    for (int i = 0; i < 5; i++) cyc(1'b1, uniq++, RND123, 1'b0);
    do_reset();
    run_win(RND123, 2, 16'h0777, -1, '0);

    // R10 and R7: constrained random mix
    tag_m = "R10"; tag_a = "R7";
    for (int i = 0; i < 3000; i++)
      cyc(($urandom_range(0, 9) < 8), 16'($urandom_range(0, 5)), 21'($urandom),
          ($urandom_range(0, 9) < 3));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule